// File: doc/BRIEF.md
# Serial Horner Polynomial Evaluator

This block evaluates an integer polynomial f(x) = a_N x^N + ... + a_1 x + a_0 by Horner's rule, one bit per clock. The argument x is held in a parallel register. The coefficients arrive as bit streams, one line per coefficient. A chain of N serial multiply-add stages computes each partial value y_k = y_(k-1) * x + a_(N-k) from the least significant bit up. Each stage works on the bit stream of the previous one, two clocks behind it.

The argument can be captured in one clock from a parallel bus, or it can be shifted in one bit at a time from a serial pin. The final value is given at full precision, (N+1)*W bits wide in two's complement. It comes out bit by bit on a serial pin while a valid flag is high. After the last bit, the full word sits in an output shift register and a done flag is raised.

A small sequencer runs the steps in order: idle, argument shift-in, calculation, finish. It uses fixed cycle counts, so the host can predict every event from the moment start is accepted.

Top module: `serial_horner`

## Requirements
- R1: With ser_mode low at the accepted start, result equals f(x) for the x_par value sampled at that edge, written as a (N+1)*W-bit two's complement number, and all W-bit values are signed.
- R2: With ser_mode high, x is taken LSB first from x_ser on the start edge and on the W-1 rising edges that follow. The result then matches R1 for that x.
- R3: Coefficient line k (coef[k]) carries a_(N-k), so line 0 is the highest-order one. Bit j of every line is sampled on the (j+1)-th rising edge after calculation begins. Calculation begins at the start edge in parallel mode, or W-1 edges after it in serial mode. From bit W onward, each line repeats its sign bit.
- R4: valid is high for exactly (N+1)*W cycles, starting 2N cycles after calculation begins. In the j-th valid cycle, counting from 0, ser_out holds result bit j.
- R5: done rises in the cycle in which valid falls. It holds, with result unchanged, until the next start is accepted, and it is low in the cycle after that edge.
- R6: Changes on x_par after the start edge have no effect on that evaluation.
- R7: After reset, valid and done are low and result is zero.
- R8: valid and done are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an evaluation (accepted while idle) |
| ser_mode | input | 1 | 1: shift x in from x_ser, 0: take x from x_par |
| x_par | input | W | Parallel argument |
| x_ser | input | 1 | Serial argument bit, LSB first |
| coef | input | N+1 | One serial coefficient line per bit, line 0 highest order |
| ser_out | output | 1 | Result bit stream, LSB first |
| valid | output | 1 | ser_out carries a result bit |
| done | output | 1 | Full result held on result |
| result | output | (N+1)*W | Parallel result, two's complement |

## Verification
The assertions assume that start is pulsed only while the block is idle and that ser_mode is steady around the accepted start. They also assume the coefficient lines follow the timing in R3, with the sign repeated. The bench keeps to these rules. It raises start only after done has been seen and holds ser_mode for the whole run. It drives coefficient bits on the falling edge, in step with its own count from the start edge, and puts random values on the lines before calculation begins so that the stage gating is exercised. In parallel runs it also moves x_par at random during calculation.

// File: rtl/shp_pkg.sv
package shp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT_X, ST_RUN, ST_FINISH} ctrl_st_e;

  // one-bit full add, returns {carry, sum}
  function automatic logic [1:0] bit_add(input logic a, input logic b, input logic ci);
    bit_add = {(a & b) | (a & ci) | (b & ci), a ^ b ^ ci};
  endfunction
endpackage

// File: rtl/horner_stage.sv
module horner_stage #(
  parameter int W   = 8,
  parameter int DLY = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] x,
  input  logic         y_in,
  input  logic         coef_in,
  input  logic         en_mul,
  input  logic         en_add,
  output logic         y_out
);
  import shp_pkg::*;

  // accumulator step: acc + (b ? x : 0), sign-extended to W+1 bits
  function automatic logic [W:0] mac_step(input logic [W-1:0] acc, input logic [W-1:0] xv,
                                          input logic b);
    mac_step = {acc[W-1], acc} + (b ? {xv[W-1], xv} : '0);
  endfunction

  logic [DLY-1:0] dline;
  logic           coef_d;
  logic [W-1:0]   acc_q;
  logic           pbit_q;
  logic           carry_q;
  logic [W:0]     step;
  logic [1:0]     sum;

  generate
    if (DLY == 1) begin : g_d1
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) dline <= '0;
        else        dline <= coef_in;
    end else begin : g_dn
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) dline <= '0;
        else        dline <= {dline[DLY-2:0], coef_in};
    end
  endgenerate
  assign coef_d = dline[DLY-1];

  assign step = mac_step(acc_q, x, y_in);
  assign sum  = bit_add(pbit_q, coef_d, carry_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      pbit_q <= 1'b0;
    end else if (!en_mul) begin
      acc_q  <= '0;
      pbit_q <= 1'b0;
    end else begin
      acc_q  <= step[W:1];
      pbit_q <= step[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carry_q <= 1'b0;
      y_out   <= 1'b0;
    end else if (!en_add) begin
      carry_q <= 1'b0;
      y_out   <= 1'b0;
    end else begin
      carry_q <= sum[1];
      y_out   <= sum[0];
    end
  end
endmodule

// File: rtl/horner_ctrl.sv
module horner_ctrl #(
  parameter int W  = 8,
  parameter int N  = 3,
  parameter int R  = (N + 1) * W,
  parameter int CW = $clog2(2 * N + R + W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         ser_mode,
  output logic         x_par_ld,
  output logic         x_shift,
  output logic         calc_on,
  output logic         valid,
  output logic         done,
  output logic [N-1:0] en_mul,
  output logic [N-1:0] en_add
);
  import shp_pkg::*;

  localparam logic [CW-1:0] LAST_CNT  = CW'(2 * N + R - 1);
  localparam logic [CW-1:0] FIRST_OUT = CW'(2 * N);
  localparam logic [CW-1:0] SHIFT_END = CW'(W - 2);

  ctrl_st_e      st_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      done  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          cnt_q <= '0;
          done  <= 1'b0;
          st_q  <= ser_mode ? ST_SHIFT_X : ST_RUN;
        end
        ST_SHIFT_X: begin
          if (cnt_q == SHIFT_END) begin
            cnt_q <= '0;
            st_q  <= ST_RUN;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_RUN: begin
          if (cnt_q == LAST_CNT) begin
            done <= 1'b1;
            st_q <= ST_FINISH;
          end else cnt_q <= cnt_q + 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign calc_on  = (st_q == ST_RUN);
  assign valid    = calc_on && (cnt_q >= FIRST_OUT);
  assign x_par_ld = (st_q == ST_IDLE) && !ser_mode;
  assign x_shift  = ((st_q == ST_IDLE) && ser_mode) || (st_q == ST_SHIFT_X);

  genvar k;
  generate
    for (k = 0; k < N; k++) begin : g_en
      assign en_mul[k] = calc_on && (cnt_q >= CW'(2 * k));
      assign en_add[k] = calc_on && (cnt_q >= CW'(2 * k + 1));
    end
  endgenerate
endmodule

// File: rtl/serial_horner.sv
module serial_horner #(
  parameter int W = 8,
  parameter int N = 3,
  localparam int R = (N + 1) * W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         ser_mode,
  input  logic [W-1:0] x_par,
  input  logic         x_ser,
  input  logic [N:0]   coef,
  output logic         ser_out,
  output logic         valid,
  output logic         done,
  output logic [R-1:0] result
);
  logic         x_par_ld, x_shift, calc_on;
  logic [N-1:0] en_mul, en_add;
  logic [W-1:0] x_q;
  logic [N:0]   chain;

  horner_ctrl #(.W(W), .N(N)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .ser_mode(ser_mode),
    .x_par_ld(x_par_ld), .x_shift(x_shift), .calc_on(calc_on),
    .valid(valid), .done(done), .en_mul(en_mul), .en_add(en_add)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        x_q <= '0;
    else if (x_par_ld) x_q <= x_par;
    else if (x_shift)  x_q <= {x_ser, x_q[W-1:1]};
  end

  assign chain[0] = coef[0];

  genvar k;
  generate
    for (k = 1; k <= N; k++) begin : g_stage
      horner_stage #(.W(W), .DLY(2 * k - 1)) u_stage (
        .clk(clk), .rst_n(rst_n), .x(x_q), .y_in(chain[k-1]), .coef_in(coef[k]),
        .en_mul(en_mul[k-1]), .en_add(en_add[k-1]), .y_out(chain[k])
      );
    end
  endgenerate

  assign ser_out = chain[N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     result <= '0;
    else if (valid) result <= {ser_out, result[R-1:1]};
  end
endmodule

module serial_horner_chk #(
  parameter int W = 8,
  parameter int N = 3,
  parameter int R = (N + 1) * W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         valid,
  input logic         done,
  input logic         calc_on,
  input logic [W-1:0] x_q,
  input logic [R-1:0] result
);
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid && done));
  a_r5_done_follows_valid: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(valid) |-> done);
  a_r5_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(result));
  a_r5_done_cleared_by_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(start));
  a_r6_x_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (calc_on && $past(calc_on)) |-> $stable(x_q));
endmodule

bind serial_horner serial_horner_chk #(.W(W), .N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .valid(valid), .done(done),
  .calc_on(calc_on), .x_q(x_q), .result(result)
);

// File: tb/serial_horner_bench.sv
module serial_horner_bench;
  localparam int W = 8;
  localparam int N = 3;
  localparam int R = (N + 1) * W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, ser_mode = 1'b0, x_ser = 1'b0;
  logic [W-1:0] x_par = '0;
  logic [N:0]   coef = '0;
  logic         ser_out, valid, done;
  logic [R-1:0] result;
  int           n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  serial_horner #(.W(W), .N(N)) u_serial_horner (
    .clk(clk), .rst_n(rst_n), .start(start), .ser_mode(ser_mode), .x_par(x_par),
    .x_ser(x_ser), .coef(coef), .ser_out(ser_out), .valid(valid), .done(done), .result(result)
  );

  // reference: plain integer Horner evaluation, wrapped to R bits
  function automatic logic [R-1:0] poly_ref(input logic [N:0][W-1:0] cf, input logic [W-1:0] xv);
    longint acc = longint'($signed(cf[0]));
    for (int k = 1; k <= N; k++) acc = acc * longint'($signed(xv)) + longint'($signed(cf[k]));
    return R'(acc);
  endfunction

  function automatic logic line_bit(input logic [W-1:0] v, input int j);
    return (j < W) ? v[j] : v[W-1];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [R-1:0] act, input logic [R-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_eval(input logic ser, input logic [W-1:0] xv, input logic [N:0][W-1:0] cf,
                          input string tag);
    logic [R-1:0] exp = poly_ref(cf, xv);
    int lead = ser ? W - 1 : 0;
    bit vok = 1'b1;
    int serr = 0;
    logic [R-1:0] held;
    @(negedge clk);
    ser_mode = ser;
    x_par = ser ? W'($urandom) : xv;
    x_ser = xv[0];
    coef = (N+1)'($urandom);
    start = 1'b1;
    @(posedge clk);
    for (int i = 0; i < 4 * R + 4 * W; i++) begin
      int c = i - lead;
      bit ev;
      @(negedge clk);
      if (i == 0) begin
        start = 1'b0;
        chk(done == 1'b0, {"R5 done cleared at start ", tag}, R'(done), '0);
      end
      if (ser && i + 1 < W) x_ser = xv[i+1];
      if (!ser) x_par = W'($urandom); // R6: ignored after start
      if (c >= 2 * N + R) break;
      ev = (c >= 2 * N) && (c < 2 * N + R);
      if (valid !== ev) vok = 1'b0;
      if (ev && ser_out !== exp[c-2*N]) serr++;
      for (int k = 0; k <= N; k++) coef[k] = (c >= 0) ? line_bit(cf[k], c) : 1'($urandom);
    end
    chk(vok, {"R4 valid window ", tag}, '0, '0);
    chk(serr == 0, {"R4 ser_out stream ", tag}, R'(serr), '0);
    chk(done === 1'b1 && valid === 1'b0, {"R5/R8 done at end ", tag}, R'({done, valid}), R'(2));
    chk(result === exp, ser ? {"R2 serial-load result ", tag} : {"R1/R3/R6 result ", tag}, result, exp);
    held = result;
    repeat (3) @(negedge clk);
    chk(done === 1'b1 && result === held, {"R5 result held ", tag}, result, held);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [N:0][W-1:0] cf;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(valid === 1'b0 && done === 1'b0 && result === '0, "R7 reset state", result, '0);

    for (int k = 0; k <= N; k++) cf[k] = {1'b1, {(W-1){1'b0}}};
    run_eval(1'b0, {1'b1, {(W-1){1'b0}}}, cf, "most-negative");
    for (int k = 0; k <= N; k++) cf[k] = W'($urandom);
    run_eval(1'b0, '1, cf, "x=-1");
    run_eval(1'b0, '0, cf, "x=0");
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k <= N; k++) cf[k] = W'($urandom);
      run_eval(1'b0, W'($urandom), cf, "random-par");
    end
    for (int k = 0; k <= N; k++) cf[k] = W'($urandom);
    run_eval(1'b1, W'($urandom), cf, "random-ser");
    for (int k = 0; k <= N; k++) cf[k] = {1'b0, {(W-1){1'b1}}};
    run_eval(1'b1, {1'b1, {(W-1){1'b0}}}, cf, "extreme-ser");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule